// File: doc/BRIEF.md
# Cache-Block Management Permission and Fault Mapper

This block handles the address side of the cache-block maintenance operations (clean, flush and invalidate). When the pipeline hands it a base register value, it clears the low E bits to find the start of the enclosing cache block. The block is 2^E bytes long, and E is an exponent held in a small runtime-writable register. The block then sends the aligned virtual address and the block byte count to an external translation and permission unit. It waits for the answer and gives the pipeline either a success or one exception code together with the faulting virtual address.

The permission rule is lenient in one direction and strict in the other. The operation succeeds when either the read check or the write check over the whole block passes. When both checks fail, the write-side fault is reported. Every fault the block reports is rewritten into its store/AMO form, because maintenance operations always report as stores. Permission that comes only from instruction fetch grants nothing. The block does no cache maintenance of its own; translation, physical protection and the cache all sit outside it.

Top module: `cbm_perm_mapper`

## Requirements
- R1: After a synchronous reset, `done` is low, `op_ready` is high, `xl_req_valid` is low, and the block-size exponent is 6 (64-byte blocks).
- R2: The address sent to translation is the accepted `op_rs1` with its low E bits cleared, where E is the exponent at acceptance. `xl_req_bytes` carries 2^E.
- R3: A write of a value from 0 to 12 on the exponent port sets E for later operations. A write of a value above 12 is ignored, and E keeps its previous value.
- R4: When translation succeeds and the read or the write permission (or both) is granted, the result is success: `done_ok` is high, `exc_code` is 0 and `exc_vaddr` is 0.
- R5: When translation succeeds and neither read nor write is permitted, the reported fault is the write-check code, remapped as in R6.
- R6: Fault codes are remapped as follows. Load access fault (5) becomes store/AMO access fault (7), and load page fault (13) becomes store/AMO page fault (15). Codes 7 and 15 pass through unchanged. Any other code, such as 6 for a misaligned store, is reported as 7.
- R7: The fetch-permission response bit has no effect on the outcome.
- R8: A translation failure is reported through the mapping of R6 and takes precedence over the permission bits.
- R9: On a fault, `exc_vaddr` equals the aligned virtual address that was sent to translation.
- R10: The translation request stays asserted, with a stable address, until `xl_req_ready` is high. New operations are accepted only while `op_ready` is high. `done` is high for exactly one cycle per operation, with exactly one of `done_ok` and `done_exc` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exp_wr_en | input | 1 | Write strobe for the block-size exponent |
| exp_wr_val | input | EXP_W | New exponent value (writes above MAX_EXP are dropped) |
| op_valid | input | 1 | Pipeline presents a maintenance operation |
| op_ready | output | 1 | Block is idle and accepts an operation |
| op_rs1 | input | XLEN | Base register value of the operation |
| xl_req_valid | output | 1 | Translation request valid |
| xl_req_ready | input | 1 | Translation unit takes the request |
| xl_req_vaddr | output | XLEN | Block-aligned virtual address |
| xl_req_bytes | output | MAX_EXP+1 | Block size in bytes (2^E) |
| xl_rsp_valid | input | 1 | Translation/permission response valid |
| xl_rsp_fail | input | 1 | Translation failed |
| xl_rsp_code | input | CODE_W | Exception code of the translation failure |
| xl_rsp_rd_ok | input | 1 | Read permitted over the whole block |
| xl_rsp_wr_ok | input | 1 | Write permitted over the whole block |
| xl_rsp_wr_code | input | CODE_W | Exception code of the failed write check |
| xl_rsp_x_ok | input | 1 | Fetch permitted (does not grant access) |
| done | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | Completion with success |
| done_exc | output | 1 | Completion with an exception |
| exc_code | output | CODE_W | Store-form exception code |
| exc_vaddr | output | XLEN | Faulting aligned virtual address |

## Verification
The bench builds the block with XLEN of 32 and keeps the default exponent range of 0 to 12 and the reset exponent of 6. With a 32-bit address, the bench can work out each expected aligned address with plain mask arithmetic. The block can still be driven across the whole exponent range, from single-byte blocks up to 4096-byte blocks, and can be shown to drop an out-of-range exponent. The scoreboard covers every branch of the fault remapping, the precedence of translation failure over the permission bits, and requests that the translation unit holds off for several cycles.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int CODE_W = 5;

  localparam logic [CODE_W-1:0] EXC_LD_ACCESS = 5'd5;
  localparam logic [CODE_W-1:0] EXC_ST_ACCESS = 5'd7;
  localparam logic [CODE_W-1:0] EXC_LD_PAGE   = 5'd13;
  localparam logic [CODE_W-1:0] EXC_ST_PAGE   = 5'd15;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XLATE = 2'd1,
    ST_CHECK = 2'd2,
    ST_DONE  = 2'd3
  } cbm_state_e;
endpackage

// File: rtl/cbm_exp_reg.sv
module cbm_exp_reg #(
  parameter int EXP_W     = 4,
  parameter int MAX_EXP   = 12,
  parameter int RESET_EXP = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [EXP_W-1:0] wr_val,
  output logic [EXP_W-1:0] exp_q
);
  localparam logic [EXP_W-1:0] LIMIT = EXP_W'(MAX_EXP);
  localparam logic [EXP_W-1:0] INIT  = EXP_W'(RESET_EXP);

  // Out-of-range writes are dropped so the exponent never exceeds the limit.
  always_ff @(posedge clk) begin
    if (rst) begin
      exp_q <= INIT;
    end else if (wr_en && (wr_val <= LIMIT)) begin
      exp_q <= wr_val;
    end
  end
endmodule

// File: rtl/cbm_align.sv
module cbm_align #(
  parameter int XLEN    = 64,
  parameter int EXP_W   = 4,
  parameter int MAX_EXP = 12
) (
  input  logic [XLEN-1:0]  base,
  input  logic [EXP_W-1:0] exp_i,
  output logic [XLEN-1:0]  aligned,
  output logic [MAX_EXP:0] bytes
);
  localparam int BYTES_W = MAX_EXP + 1;

  // Bit i survives only when it lies at or above the exponent.
  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    if (i < MAX_EXP) begin : g_low
      assign aligned[i] = base[i] & (exp_i <= EXP_W'(i));
    end else begin : g_high
      assign aligned[i] = base[i];
    end
  end

  assign bytes = BYTES_W'(1) << exp_i;
endmodule

// File: rtl/cbm_fault_map.sv
module cbm_fault_map
  import cbm_pkg::*;
(
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_out
);
  // Every reported fault takes its store/AMO form; unexpected codes fold to access fault.
  always_comb begin
    unique case (code_in)
      EXC_LD_ACCESS, EXC_ST_ACCESS: code_out = EXC_ST_ACCESS;
      EXC_LD_PAGE,   EXC_ST_PAGE:   code_out = EXC_ST_PAGE;
      default:                      code_out = EXC_ST_ACCESS;
    endcase
  end
endmodule

// File: rtl/cbm_verdict.sv
module cbm_verdict
  import cbm_pkg::*;
(
  input  logic              xl_fail,
  input  logic [CODE_W-1:0] xl_code,
  input  logic              rd_ok,
  input  logic              wr_ok,
  input  logic [CODE_W-1:0] wr_code,
  output logic              ok,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-1:0] xl_mapped;
  logic [CODE_W-1:0] wr_mapped;

  cbm_fault_map u_map_xl (.code_in(xl_code), .code_out(xl_mapped));
  cbm_fault_map u_map_wr (.code_in(wr_code), .code_out(wr_mapped));

  always_comb begin
    if (xl_fail) begin
      ok   = 1'b0;
      code = xl_mapped;
    end else if (rd_ok || wr_ok) begin
      ok   = 1'b1;
      code = '0;
    end else begin
      ok   = 1'b0;
      code = wr_mapped;
    end
  end
endmodule

// File: rtl/cbm_perm_mapper.sv
module cbm_perm_mapper
  import cbm_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int EXP_W     = 4,
  parameter int MAX_EXP   = 12,
  parameter int RESET_EXP = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               exp_wr_en,
  input  logic [EXP_W-1:0]   exp_wr_val,
  input  logic               op_valid,
  output logic               op_ready,
  input  logic [XLEN-1:0]    op_rs1,
  output logic               xl_req_valid,
  input  logic               xl_req_ready,
  output logic [XLEN-1:0]    xl_req_vaddr,
  output logic [MAX_EXP:0]   xl_req_bytes,
  input  logic               xl_rsp_valid,
  input  logic               xl_rsp_fail,
  input  logic [CODE_W-1:0]  xl_rsp_code,
  input  logic               xl_rsp_rd_ok,
  input  logic               xl_rsp_wr_ok,
  input  logic [CODE_W-1:0]  xl_rsp_wr_code,
  input  logic               xl_rsp_x_ok,
  output logic               done,
  output logic               done_ok,
  output logic               done_exc,
  output logic [CODE_W-1:0]  exc_code,
  output logic [XLEN-1:0]    exc_vaddr
);
  cbm_state_e        state_q;
  logic [EXP_W-1:0]  exp_q;
  logic [XLEN-1:0]   aligned;
  logic [MAX_EXP:0]  bytes;
  logic [XLEN-1:0]   vaddr_q;
  logic [MAX_EXP:0]  bytes_q;
  logic              v_ok;
  logic [CODE_W-1:0] v_code;
  logic              ok_q;
  logic [CODE_W-1:0] code_q;
  logic [XLEN-1:0]   fa_q;
  logic              fetch_perm_unused;

  // Fetch-only permission never grants access to a maintenance operation.
  assign fetch_perm_unused = xl_rsp_x_ok;

  cbm_exp_reg #(
    .EXP_W(EXP_W), .MAX_EXP(MAX_EXP), .RESET_EXP(RESET_EXP)
  ) u_exp (
    .clk(clk), .rst(rst), .wr_en(exp_wr_en), .wr_val(exp_wr_val), .exp_q(exp_q)
  );

  cbm_align #(
    .XLEN(XLEN), .EXP_W(EXP_W), .MAX_EXP(MAX_EXP)
  ) u_align (
    .base(op_rs1), .exp_i(exp_q), .aligned(aligned), .bytes(bytes)
  );

  cbm_verdict u_verdict (
    .xl_fail(xl_rsp_fail), .xl_code(xl_rsp_code),
    .rd_ok(xl_rsp_rd_ok), .wr_ok(xl_rsp_wr_ok), .wr_code(xl_rsp_wr_code),
    .ok(v_ok), .code(v_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      vaddr_q <= '0;
      bytes_q <= '0;
      ok_q    <= 1'b0;
      code_q  <= '0;
      fa_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (op_valid) begin
          vaddr_q <= aligned;
          bytes_q <= bytes;
          state_q <= ST_XLATE;
        end
        ST_XLATE: if (xl_req_ready) state_q <= ST_CHECK;
        ST_CHECK: if (xl_rsp_valid) begin
          ok_q    <= v_ok;
          code_q  <= v_code;
          fa_q    <= v_ok ? '0 : vaddr_q;
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign op_ready     = (state_q == ST_IDLE);
  assign xl_req_valid = (state_q == ST_XLATE);
  assign xl_req_vaddr = vaddr_q;
  assign xl_req_bytes = bytes_q;
  assign done         = (state_q == ST_DONE);
  assign done_ok      = done & ok_q;
  assign done_exc     = done & ~ok_q;
  assign exc_code     = code_q;
  assign exc_vaddr    = fa_q;
endmodule

// File: rtl/cbm_perm_mapper_chk.sv
module cbm_perm_mapper_chk #(
  parameter int XLEN    = 64,
  parameter int MAX_EXP = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             op_ready,
  input logic             xl_req_valid,
  input logic             xl_req_ready,
  input logic [XLEN-1:0]  xl_req_vaddr,
  input logic [MAX_EXP:0] xl_req_bytes,
  input logic             done,
  input logic             done_ok,
  input logic             done_exc,
  input logic [4:0]       exc_code,
  input logic [XLEN-1:0]  exc_vaddr
);
  logic [XLEN-1:0] blk_mask;
  assign blk_mask = XLEN'(xl_req_bytes) - XLEN'(1);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_outcome_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (done_ok != done_exc));
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (xl_req_valid && !xl_req_ready) |=> (xl_req_valid && $stable(xl_req_vaddr)));
  assert_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (xl_req_valid || done) |-> !op_ready);
  assert_store_code_R6: assert property (@(posedge clk) disable iff (rst)
    done_exc |-> (exc_code == 5'd7 || exc_code == 5'd15));
  assert_ok_clean_R4: assert property (@(posedge clk) disable iff (rst)
    done_ok |-> (exc_code == 5'd0 && exc_vaddr == '0));
  assert_req_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    xl_req_valid |-> ($countones(xl_req_bytes) == 1 && (xl_req_vaddr & blk_mask) == '0));
endmodule

bind cbm_perm_mapper cbm_perm_mapper_chk #(.XLEN(XLEN), .MAX_EXP(MAX_EXP)) u_chk (
  .clk(clk), .rst(rst), .op_ready(op_ready),
  .xl_req_valid(xl_req_valid), .xl_req_ready(xl_req_ready),
  .xl_req_vaddr(xl_req_vaddr), .xl_req_bytes(xl_req_bytes),
  .done(done), .done_ok(done_ok), .done_exc(done_exc),
  .exc_code(exc_code), .exc_vaddr(exc_vaddr)
);

// File: tb/cbm_perm_mapper_bench.sv
`timescale 1ns/1ps
module cbm_perm_mapper_bench;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            exp_wr_en = 1'b0;
  logic [3:0]      exp_wr_val = '0;
  logic            op_valid = 1'b0;
  logic            op_ready;
  logic [XLEN-1:0] op_rs1 = '0;
  logic            xl_req_valid;
  logic            xl_req_ready = 1'b0;
  logic [XLEN-1:0] xl_req_vaddr;
  logic [12:0]     xl_req_bytes;
  logic            xl_rsp_valid = 1'b0;
  logic            xl_rsp_fail = 1'b0;
  logic [4:0]      xl_rsp_code = '0;
  logic            xl_rsp_rd_ok = 1'b0;
  logic            xl_rsp_wr_ok = 1'b0;
  logic [4:0]      xl_rsp_wr_code = '0;
  logic            xl_rsp_x_ok = 1'b0;
  logic            done, done_ok, done_exc;
  logic [4:0]      exc_code;
  logic [XLEN-1:0] exc_vaddr;

  cbm_perm_mapper #(.XLEN(XLEN)) u_cbm_perm_mapper (.*);

  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int cur_e    = 6;
  logic [37:0] exp_q[$];
  string       tag_q[$];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [4:0] store_form(input logic [4:0] c);
    if (c == 5'd13 || c == 5'd15) return 5'd15;
    return 5'd7;
  endfunction

  // Monitor: pops one expected completion per done pulse.
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R10: actual unexpected done, expected none");
      end else begin
        logic [37:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " ok"},    64'(done_ok),   64'(e[37]));
        check({t, " exc"},   64'(done_exc),  64'(!e[37]));
        check({t, " code"},  64'(exc_code),  64'(e[36:32]));
        check({t, " vaddr"}, 64'(exc_vaddr), 64'(e[31:0]));
      end
    end
  end

  task automatic set_exp(input logic [3:0] v);
    @(negedge clk);
    exp_wr_en = 1'b1; exp_wr_val = v;
    @(negedge clk);
    exp_wr_en = 1'b0;
    if (v <= 4'd12) cur_e = int'(v);
  endtask

  task automatic run_op(input string tag, input logic [31:0] rs1, input int stall,
                        input logic fail, input logic [4:0] fcode,
                        input logic rd, input logic wr, input logic [4:0] wcode,
                        input logic xok, input logic exp_ok, input logic [4:0] exp_code);
    logic [31:0] al;
    al = rs1 & ~((32'd1 << cur_e) - 32'd1);
    @(negedge clk);
    op_valid = 1'b1; op_rs1 = rs1;
    @(negedge clk);
    op_valid = 1'b0; op_rs1 = 32'hFFFF_FFFF;
    check({tag, " R2 req_valid"}, 64'(xl_req_valid), 64'd1);
    check({tag, " R2 aligned vaddr"}, 64'(xl_req_vaddr), 64'(al));
    check({tag, " R2 bytes"}, 64'(xl_req_bytes), 64'(32'd1 << cur_e));
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      check({tag, " R10 hold valid"}, 64'(xl_req_valid), 64'd1);
      check({tag, " R10 hold vaddr"}, 64'(xl_req_vaddr), 64'(al));
    end
    xl_req_ready = 1'b1;
    @(negedge clk);
    xl_req_ready = 1'b0;
    check({tag, " R10 busy"}, 64'(op_ready), 64'd0);
    xl_rsp_valid = 1'b1; xl_rsp_fail = fail; xl_rsp_code = fcode;
    xl_rsp_rd_ok = rd; xl_rsp_wr_ok = wr; xl_rsp_wr_code = wcode; xl_rsp_x_ok = xok;
    exp_q.push_back({exp_ok, exp_code, exp_ok ? 32'd0 : al});
    tag_q.push_back(tag);
    @(negedge clk);
    xl_rsp_valid = 1'b0; xl_rsp_fail = 1'b0; xl_rsp_rd_ok = 1'b0;
    xl_rsp_wr_ok = 1'b0; xl_rsp_x_ok = 1'b0;
    @(negedge clk);
    check({tag, " R10 single done"}, 64'(done), 64'd0);
    check({tag, " R10 drained"}, 64'(exp_q.size()), 64'd0);
    check({tag, " R10 idle"}, 64'(op_ready), 64'd1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung, expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 done", 64'(done), 64'd0);
    check("R1 op_ready", 64'(op_ready), 64'd1);
    check("R1 req_valid", 64'(xl_req_valid), 64'd0);
    // R1: default exponent 6
    run_op("R1 R4 rd only", 32'h1234_5678, 0, 0, 0, 1, 0, 5'd7, 0, 1, 5'd0);
    run_op("R4 wr only", 32'h0000_00FF, 2, 0, 0, 0, 1, 5'd7, 0, 1, 5'd0);
    run_op("R4 both", 32'h8000_0041, 0, 0, 0, 1, 1, 5'd7, 0, 1, 5'd0);
    run_op("R5 R9 wr acc", 32'hCAFE_F00D, 1, 0, 0, 0, 0, 5'd7, 0, 0, 5'd7);
    run_op("R5 R6 wr ld acc", 32'h0000_1001, 0, 0, 0, 0, 0, 5'd5, 0, 0, 5'd7);
    run_op("R5 R6 wr ld pg", 32'h0000_2002, 0, 0, 0, 0, 0, 5'd13, 0, 0, 5'd15);
    run_op("R5 R6 wr st pg", 32'h0000_3003, 0, 0, 0, 0, 0, 5'd15, 0, 0, 5'd15);
    run_op("R6 odd code", 32'h0000_4004, 0, 0, 0, 0, 0, 5'd6, 0, 0, 5'd7);
    run_op("R7 fetch only", 32'h0000_5005, 0, 0, 0, 0, 0, 5'd13, 1, 0, 5'd15);
    run_op("R8 xl ld pg", 32'h7777_7777, 0, 1, 5'd13, 1, 1, 5'd7, 0, 0, 5'd15);
    run_op("R8 xl ld acc", 32'h7777_7777, 0, 1, 5'd5, 0, 0, 5'd15, 0, 0, 5'd7);
    set_exp(4'd0);
    run_op("R3 exp0", 32'hDEAD_BEEF, 0, 0, 0, 0, 0, 5'd7, 0, 0, 5'd7);
    set_exp(4'd12);
    run_op("R3 exp12", 32'hABCD_EFFF, 0, 0, 0, 0, 0, 5'd13, 0, 0, 5'd15);
    set_exp(4'd13);
    run_op("R3 exp13 ignored", 32'h0123_4FFF, 0, 0, 0, 0, 1, 5'd7, 0, 1, 5'd0);
    set_exp(4'd15);
    run_op("R3 exp15 ignored", 32'h0123_5ABC, 0, 0, 0, 0, 0, 5'd5, 0, 0, 5'd7);
    set_exp(4'd3);
    run_op("R3 R9 exp3", 32'h0000_00FF, 3, 0, 0, 0, 0, 5'd7, 1, 0, 5'd7);
    check("R10 queue empty", 64'(exp_q.size()), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule